// File: doc/BRIEF.md
# Cascadable Quadrature Phase Counter

This block counts motion pulses from two pairs of external phase inputs (A/B and C/D). A two-flop synchronizer samples each input on the system clock, and an edge detector follows it. A per-channel decoder then turns the edges into up or down count steps. Three decoding schemes are supported:

- four-edge quadrature;
- pulse plus direction;
- two-edge counting on phase B alone.

Each of the two 16-bit channels has its own mode register, count register, period register and direction flag. When a channel counts up from a count equal to its period, the count clears to zero instead of incrementing.

A shared mode register can join the two channels into one 32-bit counter. In that configuration the lower channel counts from a selectable input pair, and the upper channel follows its carries and borrows. Software reaches all state through a simple word-wide write strobe with an address, plus a combinational read port.

Top module: `phase_count_unit`

## Requirements
- R1: After reset, both counts are 0, both period registers are 0xFFFF, both mode registers and both status registers read 0, and the shared register reads 0.
- R2: Register addresses are: 0 and 1 are the mode registers (8 bits), 2 and 3 are the counts, 4 and 5 are the periods, 6 and 7 are the status registers, and 8 is the shared register (bits 1:0). Channel 0 uses the even address of each pair. Every register reads back the value written to it.
- R3: With mode field (bits 3:0 of the mode register) equal to 4, a channel steps on every edge of either input of its pair. On an edge of the first input, it counts up when the new first-input level differs from the second input. On an edge of the second input, it counts up when the new second-input level equals the first input.
- R4: In mode 4, a sample in which both inputs of the pair change at once leaves the count unchanged.
- R5: With mode 5, only a rising edge of the first input (A, or C for channel 1) steps the count. It counts up when the companion input (B or D) is high and down when it is low.
- R6: With mode 7, only edges of the second input (B or D) step the count, both edges counting. The step is up when the new second-input level equals the first input.
- R7: Any other mode value (including 0, 6 and 9) leaves the count unchanged.
- R8: Status bit 7 holds the direction of the channel's most recent step: 1 for up, 0 for down.
- R9: An up step taken when the count equals the period loads 0. A down step from 0 wraps to all-ones.
- R10: Writing a count register loads it. A load wins over a count step in the same cycle.
- R11: When shared bit 0 is 1, the channels form one 32-bit counter with period {period1, period0}. Channel 0's mode applies, and address 2 and address 4 read and write all 32 bits. The upper half increments when the lower half wraps up from 0xFFFF and decrements when it wraps down from 0. The clear of R9 compares all 32 bits.
- R12: In 32-bit operation, shared bit 1 selects the input pair: 0 selects A/B and 1 selects C/D. The unselected pair has no effect.
- R13: A count changes at the third rising clock edge after an input change: two edges for the synchronizer and one for the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_a | input | 1 | Phase input A (pair 0, first) |
| phase_b | input | 1 | Phase input B (pair 0, second) |
| phase_c | input | 1 | Phase input C (pair 1, first) |
| phase_d | input | 1 | Phase input D (pair 1, second) |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |

## Verification
A register write takes effect at the clock edge where `wr_en` is high, and `rdata` shows it right after that edge. A phase-input change reaches the count at the third rising edge. The bench drives inputs on falling edges and waits four falling edges after each pin change before reading a count. The latency test reads the count after the second and after the third rising edge to pin that window exactly. For the load-versus-step case, the write strobe is placed on the third edge after a pin change, so both events land in the same cycle.

// File: rtl/pcu_pkg.sv
// Package: shared constants for the phase counting unit.
// Assumes: mode field is 4 bits; addresses fit in 4 bits.
package pcu_pkg;
    localparam logic [3:0] MODE_X4  = 4'd4;
    localparam logic [3:0] MODE_PD  = 4'd5;
    localparam logic [3:0] MODE_X2B = 4'd7;

    localparam logic [3:0] A_MODE0 = 4'd0;
    localparam logic [3:0] A_MODE1 = 4'd1;
    localparam logic [3:0] A_CNT0  = 4'd2;
    localparam logic [3:0] A_CNT1  = 4'd3;
    localparam logic [3:0] A_PER0  = 4'd4;
    localparam logic [3:0] A_PER1  = 4'd5;
    localparam logic [3:0] A_STS0  = 4'd6;
    localparam logic [3:0] A_STS1  = 4'd7;
    localparam logic [3:0] A_SHR   = 4'd8;
endpackage

// File: rtl/pcu_sync_edge.sv
// Module: two-flop synchronizer plus change detector for N asynchronous inputs.
// Assumes: inputs are slow relative to clk; chg is high for one cycle per change.
module pcu_sync_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] lvl,
    output logic [N-1:0] chg
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2, prev;
        // Synchronize one input and remember its last synchronized value.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                prev <= 1'b0;
            end else begin
                s1   <= pin[i];
                s2   <= s1;
                prev <= s2;
            end
        end
        assign lvl[i] = s2;
        assign chg[i] = s2 ^ prev;
    end
endmodule

// File: rtl/pcu_step_dec.sv
// Module: turns edges of one input pair into a count step and direction.
// Assumes: p is the first input of the pair, q the second; levels are post-change.
module pcu_step_dec
    import pcu_pkg::*;
(
    input  logic [3:0] mode,
    input  logic       p_lvl,
    input  logic       q_lvl,
    input  logic       p_chg,
    input  logic       q_chg,
    output logic       step,
    output logic       up
);
    // Decode step and direction for the selected counting scheme.
    always_comb begin
        step = 1'b0;
        up   = 1'b0;
        case (mode)
            MODE_X4: begin
                step = p_chg ^ q_chg;
                up   = p_chg ? (p_lvl != q_lvl) : (q_lvl == p_lvl);
            end
            MODE_PD: begin
                step = p_chg & p_lvl;
                up   = q_lvl;
            end
            MODE_X2B: begin
                step = q_chg;
                up   = (q_lvl == p_lvl);
            end
            default: begin
                step = 1'b0;
                up   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pcu_chan.sv
// Module: one W-bit count register with load, clear and up/down stepping.
// Assumes: priority is load, then clear, then step; inc and dec never both high.
module pcu_chan #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    // Update the count with load > clear > step priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
        else if (dec) cnt <= cnt - 1'b1;
    end

    assert_preload_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> cnt == $past(ld_val));
endmodule

// File: rtl/phase_count_unit.sv
// Module: two-channel quadrature/phase counter, chainable into one 32-bit counter.
// Assumes: single clock domain for registers; phase pins are asynchronous.
module phase_count_unit
    import pcu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 4,
    localparam int DATA_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase_a,
    input  logic              phase_b,
    input  logic              phase_c,
    input  logic              phase_d,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

    logic [7:0]       mode_q [2];
    logic [CNT_W-1:0] per_q  [2];
    logic [CNT_W-1:0] cnt    [2];
    logic [1:0]       dir_q;
    logic [1:0]       shr_q;
    logic [3:0]       lvl, chg;
    logic             chain, src_cd;
    logic             st0, up0, st1, up1;
    logic [1:0]       ld, clr, inc, dec;
    logic [CNT_W-1:0] ld_val [2];

    assign chain  = shr_q[0];
    assign src_cd = chain & shr_q[1];

    pcu_sync_edge #(.N(4)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .pin({phase_d, phase_c, phase_b, phase_a}),
        .lvl(lvl), .chg(chg)
    );

    pcu_step_dec dec0_i (
        .mode(mode_q[0][3:0]),
        .p_lvl(src_cd ? lvl[2] : lvl[0]), .q_lvl(src_cd ? lvl[3] : lvl[1]),
        .p_chg(src_cd ? chg[2] : chg[0]), .q_chg(src_cd ? chg[3] : chg[1]),
        .step(st0), .up(up0)
    );

    pcu_step_dec dec1_i (
        .mode(mode_q[1][3:0]),
        .p_lvl(lvl[2]), .q_lvl(lvl[3]), .p_chg(chg[2]), .q_chg(chg[3]),
        .step(st1), .up(up1)
    );

    logic at_per0, at_per1, at_per32;
    assign at_per0  = cnt[0] == per_q[0];
    assign at_per1  = cnt[1] == per_q[1];
    assign at_per32 = {cnt[1], cnt[0]} == {per_q[1], per_q[0]};

    // Derive loads, clears and steps for both channels in either width.
    always_comb begin
        ld[0]     = wr_en && addr == A_CNT0;
        ld_val[0] = wdata[CNT_W-1:0];
        ld[1]     = wr_en && (addr == A_CNT1 || (chain && addr == A_CNT0));
        ld_val[1] = (chain && addr == A_CNT0) ? wdata[DATA_W-1:CNT_W] : wdata[CNT_W-1:0];
        inc[0]    = st0 & up0;
        dec[0]    = st0 & ~up0;
        clr[0]    = inc[0] & (chain ? at_per32 : at_per0);
        if (chain) begin
            clr[1] = clr[0];
            inc[1] = inc[0] & (cnt[0] == ONES);
            dec[1] = dec[0] & (cnt[0] == '0);
        end else begin
            clr[1] = st1 & up1 & at_per1;
            inc[1] = st1 & up1;
            dec[1] = st1 & ~up1;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_ch
        pcu_chan #(.W(CNT_W)) chan_i (
            .clk(clk), .rst_n(rst_n), .ld(ld[i]), .ld_val(ld_val[i]),
            .clr(clr[i]), .inc(inc[i]), .dec(dec[i]), .cnt(cnt[i])
        );
    end

    // Configuration registers: modes, periods and shared control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q[0] <= '0;
            mode_q[1] <= '0;
            per_q[0]  <= ONES;
            per_q[1]  <= ONES;
            shr_q     <= '0;
        end else if (wr_en) begin
            case (addr)
                A_MODE0: mode_q[0] <= wdata[7:0];
                A_MODE1: mode_q[1] <= wdata[7:0];
                A_PER0: begin
                    per_q[0] <= wdata[CNT_W-1:0];
                    if (chain) per_q[1] <= wdata[DATA_W-1:CNT_W];
                end
                A_PER1:  per_q[1] <= wdata[CNT_W-1:0];
                A_SHR:   shr_q    <= wdata[1:0];
                default: ;
            endcase
        end
    end

    // Direction flags follow the most recent step of each channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else begin
            if (st0) dir_q[0] <= up0;
            if (chain ? st0 : st1) dir_q[1] <= chain ? up0 : up1;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE0: rdata[7:0] = mode_q[0];
            A_MODE1: rdata[7:0] = mode_q[1];
            A_CNT0:  rdata = chain ? {cnt[1], cnt[0]} : {{CNT_W{1'b0}}, cnt[0]};
            A_CNT1:  rdata[CNT_W-1:0] = cnt[1];
            A_PER0:  rdata = chain ? {per_q[1], per_q[0]} : {{CNT_W{1'b0}}, per_q[0]};
            A_PER1:  rdata[CNT_W-1:0] = per_q[1];
            A_STS0:  rdata[7] = dir_q[0];
            A_STS1:  rdata[7] = dir_q[1];
            A_SHR:   rdata[1:0] = shr_q;
            default: rdata = '0;
        endcase
    end

    assert_illegal_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_cd && mode_q[0][3:0] == MODE_X4 && chg[0] && chg[1]) |-> !st0);

    assert_period_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain && st0 && up0 && at_per0 && !ld[0]) |=> cnt[0] == '0);

    assert_dir_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!chain && st1) |=> dir_q[1] == $past(up1));

    assert_carry_up_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (chain && st0 && up0 && cnt[0] == ONES && !at_per32 && !ld[0] && !ld[1])
        |=> cnt[1] == $past(cnt[1]) + 1'b1);
endmodule

// File: tb/phase_count_unit_tb_top.sv
module phase_count_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pa = 0, pb = 0, pc = 0, pd = 0;
    logic        wr_en = 0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    int          total = 0, bad = 0;
    logic        done = 0;

    always #4 clk = ~clk;

    phase_count_unit dut_i (
        .clk(clk), .rst_n(rst_n), .phase_a(pa), .phase_b(pb), .phase_c(pc), .phase_d(pd),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // x4 sequence on A/B: {a, b, expected count}
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {1'b1, 1'b0, 16'h0001}, {1'b1, 1'b1, 16'h0002}, {1'b0, 1'b1, 16'h0003},
        {1'b0, 1'b0, 16'h0004}, {1'b0, 1'b1, 16'h0003}, {1'b1, 1'b1, 16'h0002},
        {1'b1, 1'b0, 16'h0001}, {1'b0, 1'b0, 16'h0000}, {1'b0, 1'b1, 16'hFFFF},
        {1'b0, 1'b0, 16'h0000}, {1'b1, 1'b1, 16'h0000}, {1'b0, 1'b0, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pins(input logic a, input logic b, input logic c, input logic d);
        @(negedge clk);
        pa = a; pb = b; pc = c; pd = d;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'd2, v); chk("R1 cnt0", v, 0);
        rd(4'd5, v); chk("R1 per1", v, 32'hFFFF);
        rd(4'd0, v); chk("R1 mode0", v, 0);
        rd(4'd6, v); chk("R1 sts0", v, 0);
        rd(4'd8, v); chk("R1 shared", v, 0);

        // R3 / R4 table walk, x4 on channel 0
        wr(4'd0, 32'h04);
        rd(4'd0, v); chk("R2 mode0 readback", v, 32'h04);
        for (int i = 0; i < NV; i++) begin
            pins(VEC[i][17], VEC[i][16], 1'b0, 1'b0);
            rd(4'd2, v);
            chk((i >= 10) ? "R4 illegal hold" : "R3 x4 step", v, {16'h0, VEC[i][15:0]});
        end

        // R8 direction flag
        pins(0, 1, 0, 0); rd(4'd2, v); chk("R9 wrap down", v, 32'hFFFF);
        rd(4'd6, v); chk("R8 down flag", v, 32'h00);
        pins(0, 0, 0, 0); rd(4'd6, v); chk("R8 up flag", v, 32'h80);

        // R10 preload and priority over a coincident step
        wr(4'd2, 32'h1234); rd(4'd2, v); chk("R10 preload", v, 32'h1234);
        @(negedge clk); pa = 1;
        @(negedge clk); @(negedge clk);
        wr_en = 1; addr = 4'd2; wdata = 32'h0100;
        @(negedge clk); wr_en = 0;
        repeat (3) @(negedge clk);
        rd(4'd2, v); chk("R10 load beats step", v, 32'h0100);

        // R13 latency: B rises with A high -> up
        @(negedge clk); pb = 1; addr = 4'd2;
        @(negedge clk); @(negedge clk); #1 chk("R13 not yet at edge 2", rdata, 32'h0100);
        @(negedge clk); #1 chk("R13 at edge 3", rdata, 32'h0101);
        repeat (2) @(negedge clk);

        // R9 clear on period
        wr(4'd4, 32'h3); rd(4'd4, v); chk("R2 per0 readback", v, 32'h3);
        wr(4'd2, 32'h1);
        pins(0, 1, 0, 0); pins(0, 0, 0, 0);
        rd(4'd2, v); chk("R9 reach period", v, 32'h3);
        pins(1, 0, 0, 0); rd(4'd2, v); chk("R9 clear", v, 32'h0);

        // R6 x2 on B
        wr(4'd0, 32'h07); wr(4'd2, 32'h10);
        pins(0, 0, 0, 0); rd(4'd2, v); chk("R6 A ignored", v, 32'h10);
        pins(0, 1, 0, 0); rd(4'd2, v); chk("R6 B rise down", v, 32'h0F);
        pins(0, 0, 0, 0); rd(4'd2, v); chk("R6 B fall up", v, 32'h10);

        // R7 other modes hold
        wr(4'd0, 32'h06);
        pins(0, 1, 0, 0); rd(4'd2, v); chk("R7 mode6 hold", v, 32'h10);
        wr(4'd0, 32'h09);
        pins(1, 1, 0, 0); rd(4'd2, v); chk("R7 mode9 hold", v, 32'h10);

        // R5 pulse plus direction on channel 1 (C/D)
        wr(4'd1, 32'h05);
        pins(1, 1, 0, 1); rd(4'd3, v); chk("R5 D alone", v, 32'h0);
        pins(1, 1, 1, 1); rd(4'd3, v); chk("R5 C rise up", v, 32'h1);
        pins(1, 1, 0, 1); rd(4'd3, v); chk("R5 C fall none", v, 32'h1);
        pins(1, 1, 0, 0);
        pins(1, 1, 1, 0); rd(4'd3, v); chk("R5 C rise down", v, 32'h0);
        pins(1, 1, 0, 0);
        pins(1, 1, 1, 0); rd(4'd3, v); chk("R5 wrap", v, 32'hFFFF);
        rd(4'd7, v); chk("R8 ch1 down flag", v, 32'h0);

        // R11 chained 32-bit counter on A/B
        wr(4'd8, 32'h1); wr(4'd0, 32'h04);
        wr(4'd4, 32'hFFFF_FFFF);
        wr(4'd2, 32'h0000_FFFF);
        pins(0, 1, 1, 0); rd(4'd2, v); chk("R11 carry up", v, 32'h0001_0000);
        rd(4'd3, v); chk("R11 upper half", v, 32'h0001);
        pins(1, 1, 1, 0); rd(4'd2, v); chk("R11 borrow", v, 32'h0000_FFFF);
        wr(4'd2, 32'h0);
        pins(1, 0, 1, 0); rd(4'd2, v); chk("R11 wrap down", v, 32'hFFFF_FFFF);
        wr(4'd4, 32'h0002_0000); rd(4'd4, v); chk("R11 period32", v, 32'h0002_0000);
        wr(4'd2, 32'h0002_0000);
        pins(1, 1, 1, 0); rd(4'd2, v); chk("R11 clear32", v, 32'h0);

        // R12 C/D drives the chain
        wr(4'd8, 32'h3); wr(4'd2, 32'h5);
        pins(0, 1, 1, 0); rd(4'd2, v); chk("R12 A/B ignored", v, 32'h5);
        pins(0, 1, 1, 1); rd(4'd2, v); chk("R12 D step", v, 32'h6);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule